// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream through two register stages. A holding register takes a snapshot of the parallel inputs whenever the capture strobe is high for a cycle. A separate shift register then either copies the held word or moves its bits one place toward the output, entering a new serial bit at the bottom. Because a snapshot is held apart from the shifter, the next word can be taken while the current one is still being sent.

Both strobes are one-cycle enables on a single system clock. Load and clear are active-low level controls that act every cycle. Clear wins over load, and load wins over shifting. While load is low and a capture happens in the same cycle, the word being captured goes directly into the shift register as well. Clear empties only the shift register, so the held word can be loaded again afterwards. The data width is a parameter with a default of 8.

Top module: `dbuf_serializer`

## Requirements
- R1: While `rst_n` is low, and after it is released, both the holding register and the shift register are zero, so `ser_out` is 0 and a load with no prior capture gives an all-zero word.
- R2: In a cycle with `cap_en` high the holding register takes `par_in`. With `cap_en` low it keeps its value, and changes on `par_in` do not reach the shift register or `ser_out`.
- R3: In each cycle with `load_n` low and `clear_n` high, the shift register takes the held word on the next clock edge. No `shift_en` is needed.
- R4: With `load_n` low, `shift_en` has no effect. The shift register keeps getting the held word, so `ser_out` stays at the word's top bit.
- R5: In a cycle with `load_n` low, `clear_n` high and `cap_en` high, the shift register takes the `par_in` value captured in that cycle, not the older held word.
- R6: In a cycle with `clear_n` low, the shift register becomes all zeros on the next edge. This holds whatever the values of `load_n` and `shift_en`.
- R7: Clear leaves the holding register unchanged. A later load brings back the word captured before the clear.
- R8: In a cycle with `shift_en` high and both `load_n` and `clear_n` high, bit i of the shift register takes bit i-1, and bit 0 takes `ser_in`. `ser_out` is bit W-1, so a loaded word leaves most significant bit first.
- R9: In a cycle with `shift_en`, `load_n` low and `clear_n` low all inactive, the shift register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture strobe for the holding register |
| shift_en | input | 1 | Shift strobe for the shift register |
| load_n | input | 1 | Level load from the holding register, active low |
| clear_n | input | 1 | Level clear of the shift register, active low |
| ser_in | input | 1 | Serial bit entering stage 0 |
| par_in | input | W | Parallel data word |
| ser_out | output | 1 | Serial output, the top stage of the shift register |

## Verification
The checker tests the following properties on every cycle:
- the next state of the shift register for each of the clear, load, capture-with-load, shift and idle cases;
- the capture and retention behaviour of the holding register;
- the bit that becomes visible at `ser_out` after a shift.

Some behaviour can only be shown by the bench's scenarios, which watch the serial output alone:
- the most-significant-first order of a whole word;
- the serial fill that enters behind the word;
- recovery of a held word after a clear;
- that changes on `par_in` without a capture have no effect.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_ZERO  = 2'd3
  } sr_act_e;

  // Priority: clear over load over shift.
  function automatic sr_act_e pick_act(input logic clr_n, input logic ld_n,
                                       input logic sh);
    sr_act_e a;
    if (!clr_n)     a = ACT_ZERO;
    else if (!ld_n) a = ACT_LOAD;
    else if (sh)    a = ACT_SHIFT;
    else            a = ACT_KEEP;
    return a;
  endfunction

endpackage

// File: rtl/dbuf_hold_reg.sv
module dbuf_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= d;
  end

endmodule

// File: rtl/dbuf_shift_core.sv
module dbuf_shift_core
  import dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sr_act_e      act,
  input  logic         ser_in,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;

  // Each stage's shift source: stage 0 takes the serial bit, the rest the stage below.
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign shifted[i] = ser_in;
    end else begin : g_rest
      assign shifted[i] = q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (act)
        ACT_ZERO:  q <= '0;
        ACT_LOAD:  q <= load_word;
        ACT_SHIFT: q <= shifted;
        default:   q <= q;
      endcase
    end
  end

endmodule

// File: rtl/dbuf_serializer.sv
module dbuf_serializer
  import dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         load_n,
  input  logic         clear_n,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic         ser_out
);

  localparam int TOP = W - 1;

  logic [W-1:0] hold_q;
  logic [W-1:0] shift_q;
  logic [W-1:0] load_word;
  sr_act_e      act;

  // A capture in the same cycle as a load forwards the fresh word.
  assign load_word = cap_en ? par_in : hold_q;
  assign act       = pick_act(clear_n, load_n, shift_en);

  dbuf_hold_reg #(.W(W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .d      (par_in),
    .q      (hold_q)
  );

  dbuf_shift_core #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .ser_in    (ser_in),
    .load_word (load_word),
    .q         (shift_q)
  );

  assign ser_out = shift_q[TOP];

endmodule

// File: rtl/dbuf_serializer_chk.sv
module dbuf_serializer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_en,
  input logic         shift_en,
  input logic         load_n,
  input logic         clear_n,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] shift_q,
  input logic         ser_out
);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> hold_q == $past(par_in));

  a_r2_retain: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold_q));

  a_r3_load_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n && !cap_en) |=> shift_q == $past(hold_q));

  a_r5_cap_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n && cap_en) |=> shift_q == $past(par_in));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (shift_q == '0 && !ser_out));

  a_r8_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && shift_en) |=>
      shift_q == {$past(shift_q[W-2:0]), $past(ser_in)});

  a_r8_out_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && shift_en) |=> ser_out == $past(shift_q[W-2]));

  a_r9_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !shift_en) |=> $stable(shift_q));

endmodule

bind dbuf_serializer dbuf_serializer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_en   (cap_en),
  .shift_en (shift_en),
  .load_n   (load_n),
  .clear_n  (clear_n),
  .ser_in   (ser_in),
  .par_in   (par_in),
  .hold_q   (hold_q),
  .shift_q  (shift_q),
  .ser_out  (ser_out)
);

// File: tb/tb_dbuf_serializer.sv
module tb_dbuf_serializer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_en = 1'b0;
  logic         shift_en = 1'b0;
  logic         load_n = 1'b1;
  logic         clear_n = 1'b1;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;

  always #5 clk = ~clk;

  dbuf_serializer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
    .load_n(load_n), .clear_n(clear_n), .ser_in(ser_in),
    .par_in(par_in), .ser_out(ser_out)
  );

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  item_t        sb_q[$];
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 0;
  logic [W-1:0] m_hold = '0;
  logic [W-1:0] m_sr = '0;

  // Reference model: clear first, then load (fresh word on capture), then shift.
  task automatic step(input logic cap, input logic sh, input logic ldn,
                      input logic clrn, input logic sin, input logic [W-1:0] p,
                      input string req);
    item_t it;
    @(negedge clk);
    cap_en = cap; shift_en = sh; load_n = ldn; clear_n = clrn;
    ser_in = sin; par_in = p;
    if (clrn == 1'b0)      m_sr = '0;
    else if (ldn == 1'b0)  m_sr = cap ? p : m_hold;
    else if (sh)           m_sr = (m_sr << 1) | W'(sin);
    if (cap) m_hold = p;
    it.exp = m_sr[W-1];
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, req);
  endtask

  task automatic shift_n(input int n, input logic [W-1:0] fill, input string req);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, fill[i % W], 8'h00, req);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (ser_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: ser_out=%b expected %b", it.req, ser_out, it.exp);
        end
      end
    end
  end

  initial begin : driver
    #23;
    n_chk++;
    if (ser_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: ser_out=%b expected 0 in reset", ser_out);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: held word is zero after reset; shift ones in behind it
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, "R1");
    shift_n(9, 8'hFF, "R8");
    // R2 capture, R9 idle keeps, R3 load without strobe
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R2");
    idle("R9");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R3");
    idle("R9");
    shift_n(10, 8'b0110_1001, "R8");
    // R2: par_in changes without capture do not reach the output
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, W'(8'hF0 + i), "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, "R2");
    shift_n(8, 8'h00, "R2");
    // R4: load with shift strobe high keeps the top bit
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R3");
    for (int i = 0; i < 5; i++)
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R4");
    // R5: capture with load forwards the fresh word (top bit differs from 0x3C)
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
    shift_n(8, 8'h00, "R5");
    // R6: clear during shifting, with load also low
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R3");
    shift_n(1, 8'h00, "R8");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R6");
    shift_n(8, 8'h00, "R6");
    // R7: held word survives a clear
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7");
    shift_n(8, 8'h00, "R7");
    idle("R9");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin : watchdog
    fork
      begin wait (done); end
      begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule